// File: doc/BRIEF.md
# Bit-Serial CRC-8 Generator and Checker

The block computes the 8-bit cyclic redundancy check used by single-wire identity codes, one bit at a time. Each cycle in which the bit-valid strobe is high, the incoming data bit is folded into an 8-bit shift register with XOR feedback (generator x^8 + x^5 + x^4 + 1, processed least significant bit first, which gives the reflected feedback constant 8Ch). The register is brought out directly, so the running check value can be read in any cycle.

For generation, the caller clears the register, then shifts in the 56 data bits of an identity code: the 8-bit family field first, then the 48-bit serial field, each least significant bit first. The register then holds the check byte. For checking, the caller shifts in all 64 bits, the check byte included. A correct code leaves a zero residue. Two flags report this: a residue-zero flag that holds on any whole number of bytes, and a code-valid flag that holds only after exactly 64 bits. Byte assembly and the bus protocol are handled elsewhere.

Top module: `crc8_serial`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the register is cleared to 00h and both flags are low after that edge.
- R2: A high `clr_i` at a rising edge sets `crc_o` to 00h and restarts the strobe count, so both flags are low after that edge.
- R3: When `clr_i` and `bit_vld_i` are both high at an edge, the clear wins: `crc_o` becomes 00h, the bit is discarded, and it is not counted.
- R4: With `bit_vld_i` low and `clr_i` low, `crc_o` and both flags keep their values across the edge.
- R5: On a strobe whose `bit_i` equals `crc_o[0]`, the next `crc_o` is the current value shifted right by one with a zero entering bit 7.
- R6: On a strobe whose `bit_i` differs from `crc_o[0]`, the next `crc_o` is the current value shifted right by one, then XORed with 8Ch (bits 7, 3 and 2).
- R7: After a clear and the 56 bits of bytes 02h, 1Ch, B8h, 01h, 00h, 00h, 00h, each sent least significant bit first, `crc_o` reads A2h.
- R8: Shifting the check byte in, least significant bit first, right after the 56 data bits from which it was computed returns `crc_o` to 00h.
- R9: `res_zero_o` is high exactly when `crc_o` is 00h and the number of strobes since the last clear or reset is a nonzero multiple of 8.
- R10: `code_ok_o` is high exactly when `crc_o` is 00h and exactly 64 strobes have been accepted since the last clear or reset; a 65th or later strobe keeps it low until the next clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of register and strobe count |
| bit_i | input | 1 | Serial data bit |
| bit_vld_i | input | 1 | Strobe: fold `bit_i` in at this edge |
| crc_o | output | 8 | Current shift-register value |
| res_zero_o | output | 1 | Zero residue at a byte boundary |
| code_ok_o | output | 1 | Zero residue after exactly 64 bits |

## Verification
The clear and the bit strobe can arrive in the same cycle. The bench provokes this at reset-free points in the middle of a code, with a one bit on the data line, so that a folded bit would have changed the register. The reference model applies the clear and drops the bit. The bench then checks after that edge that `crc_o` is zero and that the next eight zero bits raise the residue flag only on the eighth strobe, which shows the dropped bit was also not counted.

// File: rtl/crc8_pkg.sv
package crc8_pkg;

   localparam int unsigned CRC8_W         = 8;
   localparam logic [7:0]  CRC8_POLY_REFL = 8'h8C;
   localparam int unsigned CRC8_CODE_BITS = 64;
   localparam int unsigned CRC8_SLICE     = 8;

   // Two equivalent ways of building the one-bit update.
   typedef enum logic [0:0] {
      STEP_SHIFT_MASK = 1'b0,
      STEP_TAP_CHAIN  = 1'b1
   } step_style_e;

endpackage

// File: rtl/crc8_step.sv
module crc8_step #(
   parameter int unsigned          W     = crc8_pkg::CRC8_W,
   parameter logic [W-1:0]         POLY  = W'(crc8_pkg::CRC8_POLY_REFL),
   parameter crc8_pkg::step_style_e STYLE = crc8_pkg::STEP_SHIFT_MASK
) (
   input  logic [W-1:0] cur_i,
   input  logic         bit_i,
   output logic [W-1:0] nxt_o
);

   logic fb;
   assign fb = bit_i ^ cur_i[0];

   if (STYLE == crc8_pkg::STEP_SHIFT_MASK) begin : g_mask
      // Whole-word shift, then conditional mask.
      always_comb begin
         nxt_o = cur_i >> 1;
         if (fb) nxt_o = nxt_o ^ POLY;
      end
   end else begin : g_chain
      // One cell per register bit; taps picked by the constant.
      for (genvar i = 0; i < int'(W); i++) begin : g_cell
         if (i == int'(W) - 1) begin : g_top
            assign nxt_o[i] = fb & POLY[i];
         end else begin : g_mid
            assign nxt_o[i] = cur_i[i+1] ^ (fb & POLY[i]);
         end
      end
   end

endmodule

// File: rtl/crc8_tally.sv
module crc8_tally #(
   parameter int unsigned CODE_BITS  = crc8_pkg::CRC8_CODE_BITS,
   parameter int unsigned SLICE_BITS = crc8_pkg::CRC8_SLICE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic adv_i,
   output logic slice_end_o,
   output logic any_o,
   output logic full_o
);

   localparam int unsigned CNT_MAX = CODE_BITS + 1;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
   localparam int unsigned PH_W    = $clog2(SLICE_BITS);

   logic [CNT_W-1:0] cnt_q;
   logic [PH_W-1:0]  ph_q;
   logic             any_q;

   // Saturating count: past CODE_BITS it parks one above and stays.
   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         cnt_q <= '0;
      end else if (adv_i && (cnt_q != CNT_W'(CNT_MAX))) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // Position within the current byte, free running modulo SLICE_BITS.
   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         ph_q  <= '0;
         any_q <= 1'b0;
      end else if (adv_i) begin
         ph_q  <= ph_q + 1'b1;
         any_q <= 1'b1;
      end
   end

   assign slice_end_o = (ph_q == '0);
   assign any_o       = any_q;
   assign full_o      = (cnt_q == CNT_W'(CODE_BITS));

endmodule

// File: rtl/crc8_flags.sv
module crc8_flags #(
   parameter int unsigned W = crc8_pkg::CRC8_W
) (
   input  logic [W-1:0] crc_i,
   input  logic         slice_end_i,
   input  logic         any_i,
   input  logic         full_i,
   output logic         res_zero_o,
   output logic         code_ok_o
);

   logic is_zero;
   assign is_zero    = (crc_i == '0);
   assign res_zero_o = is_zero & any_i & slice_end_i;
   assign code_ok_o  = is_zero & full_i;

endmodule

// File: rtl/crc8_serial.sv
module crc8_serial #(
   parameter int unsigned           W          = crc8_pkg::CRC8_W,
   parameter logic [W-1:0]          POLY       = W'(crc8_pkg::CRC8_POLY_REFL),
   parameter int unsigned           CODE_BITS  = crc8_pkg::CRC8_CODE_BITS,
   parameter int unsigned           SLICE_BITS = crc8_pkg::CRC8_SLICE,
   parameter crc8_pkg::step_style_e STYLE      = crc8_pkg::STEP_SHIFT_MASK
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         bit_i,
   input  logic         bit_vld_i,
   output logic [W-1:0] crc_o,
   output logic         res_zero_o,
   output logic         code_ok_o
);

   // Elaboration-time parameter checks.
   if (W < 2) begin : g_bad_w
      $error("crc8_serial: W must be at least 2");
   end
   if (POLY[W-1] != 1'b1) begin : g_bad_poly
      $error("crc8_serial: reflected constant needs its top bit set");
   end
   if (SLICE_BITS < 2 || (SLICE_BITS & (SLICE_BITS - 1)) != 0) begin : g_bad_slice
      $error("crc8_serial: SLICE_BITS must be a power of two, at least 2");
   end
   if (CODE_BITS <= W || (CODE_BITS % SLICE_BITS) != 0) begin : g_bad_code
      $error("crc8_serial: CODE_BITS must exceed W and be whole slices");
   end

   logic [W-1:0] crc_q;
   logic [W-1:0] crc_nxt;
   logic         adv;
   logic         slice_end;
   logic         any_bits;
   logic         full;

   // Clear outranks the strobe.
   assign adv = bit_vld_i & ~clr_i;

   crc8_step #(
      .W    (W),
      .POLY (POLY),
      .STYLE(STYLE)
   ) u_step (
      .cur_i(crc_q),
      .bit_i(bit_i),
      .nxt_o(crc_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         crc_q <= '0;
      end else if (adv) begin
         crc_q <= crc_nxt;
      end
   end

   crc8_tally #(
      .CODE_BITS (CODE_BITS),
      .SLICE_BITS(SLICE_BITS)
   ) u_tally (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (clr_i),
      .adv_i      (adv),
      .slice_end_o(slice_end),
      .any_o      (any_bits),
      .full_o     (full)
   );

   crc8_flags #(
      .W(W)
   ) u_flags (
      .crc_i      (crc_q),
      .slice_end_i(slice_end),
      .any_i      (any_bits),
      .full_i     (full),
      .res_zero_o (res_zero_o),
      .code_ok_o  (code_ok_o)
   );

   assign crc_o = crc_q;

endmodule

// File: rtl/crc8_serial_chk.sv
module crc8_serial_chk #(
   parameter int unsigned  W    = 8,
   parameter logic [W-1:0] POLY = 8'h8C
) (
   input logic         clk,
   input logic         rst_n,
   input logic         clr_i,
   input logic         bit_i,
   input logic         bit_vld_i,
   input logic [W-1:0] crc_o,
   input logic         res_zero_o,
   input logic         code_ok_o
);

   p_reset_clears_r1: assert property (@(posedge clk)
      !rst_n |=> (crc_o == '0) && !res_zero_o && !code_ok_o);

   p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (crc_o == '0) && !res_zero_o && !code_ok_o);

   p_clear_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && bit_vld_i && bit_i) |=> (crc_o == '0));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !bit_vld_i) |=> $stable(crc_o) && $stable(res_zero_o) && $stable(code_ok_o));

   p_shift_plain_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && bit_vld_i && (bit_i == crc_o[0])) |=> (crc_o == ($past(crc_o) >> 1)));

   p_shift_tap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && bit_vld_i && (bit_i != crc_o[0])) |=> (crc_o == (($past(crc_o) >> 1) ^ POLY)));

   p_residue_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      res_zero_o |-> (crc_o == '0));

   p_ok_on_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
      code_ok_o |-> res_zero_o);

endmodule

bind crc8_serial crc8_serial_chk #(
   .W   (W),
   .POLY(POLY)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr_i     (clr_i),
   .bit_i     (bit_i),
   .bit_vld_i (bit_vld_i),
   .crc_o     (crc_o),
   .res_zero_o(res_zero_o),
   .code_ok_o (code_ok_o)
);

// File: tb/crc8_serial_test.sv
module crc8_serial_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr_i = 1'b0;
   logic       bit_i = 1'b0;
   logic       bit_vld_i = 1'b0;
   logic [7:0] crc_o;
   logic       res_zero_o;
   logic       code_ok_o;

   int n_run  = 0;
   int n_fail = 0;

   // Behavioural reference state.
   logic [7:0] m_crc = 8'h00;
   int         m_cnt = 0;

   always #5 clk = ~clk;

   crc8_serial uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr_i),
      .bit_i     (bit_i),
      .bit_vld_i (bit_vld_i),
      .crc_o     (crc_o),
      .res_zero_o(res_zero_o),
      .code_ok_o (code_ok_o)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      logic exp_rz, exp_ok;
      exp_rz = (m_cnt > 0) && (m_cnt % 8 == 0) && (m_crc == 8'h00);
      exp_ok = (m_cnt == 64) && (m_crc == 8'h00);
      check(tag, "crc", int'(crc_o), int'(m_crc));
      check("R9", "res_zero", int'(res_zero_o), int'(exp_rz));
      check("R10", "code_ok", int'(code_ok_o), int'(exp_ok));
   endtask

   // One clock: drive at negedge, update model at posedge, sample at next negedge.
   task automatic cyc(input logic c, input logic v, input logic b);
      string tag;
      logic  fb;
      clr_i = c; bit_vld_i = v; bit_i = b;
      if (c)      tag = v ? "R3" : "R2";
      else if (v) tag = (b ^ m_crc[0]) ? "R6" : "R5";
      else        tag = "R4";
      @(posedge clk);
      if (c) begin
         m_crc = 8'h00;
         m_cnt = 0;
      end else if (v) begin
         fb = b ^ m_crc[0];
         m_crc = m_crc >> 1;
         if (fb) m_crc = m_crc ^ 8'h8C;
         m_cnt++;
      end
      @(negedge clk);
      clr_i = 1'b0; bit_vld_i = 1'b0;
      compare_all(tag);
   endtask

   task automatic send_byte(input logic [7:0] d, input logic gaps);
      for (int i = 0; i < 8; i++) begin
         if (gaps && ($urandom % 4 == 0)) cyc(1'b0, 1'b0, 1'b1);
         cyc(1'b0, 1'b1, d[i]);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      logic [7:0] bytes [7];
      logic [7:0] chk;

      // R1: reset state
      repeat (3) @(negedge clk);
      compare_all("R1");
      rst_n = 1'b1;

      // R7: known code vector
      cyc(1'b1, 1'b0, 1'b0);
      send_byte(8'h02, 1'b0);
      send_byte(8'h1C, 1'b0);
      send_byte(8'hB8, 1'b0);
      send_byte(8'h01, 1'b0);
      for (int k = 0; k < 3; k++) send_byte(8'h00, 1'b0);
      check("R7", "known crc", int'(crc_o), 32'hA2);

      // R8, R10: append the check byte
      send_byte(8'hA2, 1'b0);
      check("R8", "residue", int'(crc_o), 0);
      check("R10", "ok after 64", int'(code_ok_o), 1);

      // R10: 65th bit drops the valid flag even with zero register
      cyc(1'b0, 1'b1, 1'b0);
      check("R10", "ok after 65", int'(code_ok_o), 0);
      for (int k = 0; k < 7; k++) cyc(1'b0, 1'b1, 1'b0);
      check("R10", "ok after 72", int'(code_ok_o), 0);
      check("R9", "rz after 72", int'(res_zero_o), 1);

      // R2, R4: clear then idle
      cyc(1'b1, 1'b0, 1'b0);
      for (int k = 0; k < 4; k++) cyc(1'b0, 1'b0, 1'b1);

      // R9: zero bits, flag only on the byte boundary
      for (int k = 0; k < 8; k++) cyc(1'b0, 1'b1, 1'b0);
      check("R9", "rz after 8 zeros", int'(res_zero_o), 1);

      // R3: clear with a strobe carrying a one, mid-stream
      send_byte(8'h5A, 1'b0);
      cyc(1'b0, 1'b1, 1'b1);
      cyc(1'b1, 1'b1, 1'b1);
      check("R3", "crc after clear+strobe", int'(crc_o), 0);
      for (int k = 0; k < 8; k++) cyc(1'b0, 1'b1, 1'b0);
      check("R3", "strobe not counted", int'(res_zero_o), 1);

      // R7, R8, R10: random codes with gaps
      for (int n = 0; n < 6; n++) begin
         cyc(1'b1, 1'b0, 1'b0);
         for (int k = 0; k < 7; k++) begin
            bytes[k] = 8'($urandom);
            send_byte(bytes[k], 1'b1);
         end
         chk = m_crc;
         check("R7", "random crc", int'(crc_o), int'(chk));
         if (n == 5) chk = chk ^ 8'h10;
         send_byte(chk, 1'b1);
         check("R10", "random ok", int'(code_ok_o), (n == 5) ? 0 : 1);
      end

      // R2: clear at arbitrary point with idle after
      send_byte(8'hC3, 1'b1);
      cyc(1'b1, 1'b0, 1'b0);
      cyc(1'b0, 1'b0, 1'b0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule